// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel: a down-counter whose rate is set by an 8-bit prescaler placed in front of it. Software programs a starting count and a control word. The control word holds enable, interrupt enable, periodic mode, a self-clearing counter-reset command and the prescale value. The counter then counts down once every (prescale + 1) reference ticks. When it reaches zero, the channel sets its bit in a status register that several channels share. In periodic mode it then reloads and keeps running. In one-shot mode it stops and drops its enable and active flags.

The bus decode is outside the block. The surrounding logic gives it a write strobe, a register select and the write data. It reads the state back through dedicated outputs. The reference clock arrives as a one-cycle tick enable, `ref_tick`, generated elsewhere. The interrupt line combines the interrupt enable with the channel's status bit.

Top module: `ptimer_channel`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x00000005, `init_rd`, `count_rd` and `status_rd` read 0, and `irq` is low.
- R2: A control write (`wr_sel` = 0) stores bit 30 (enable), bit 29 (interrupt enable), bit 27 (periodic) and bits 7:0 (prescale). Written bits 31, 25 and 24:8 are dropped. In `ctrl_rd`, bit 25 is the active flag, which equals the enable after every control write, and bit 26 always reads 0.
- R3: A control write with bit 26 set reloads the count from the initial-count register and restarts the prescaler phase. If bit 30 is set in the same write, the enable is discarded.
- R4: A write with `wr_sel` = 1 stores `wr_data` into the initial-count register and loads it into the count at once. A `wr_sel` value of 3 writes nothing.
- R5: While the channel is enabled, the count drops by one on the (prescale + 1)-th `ref_tick` since the last step or reload. The prescaler phase restarts from zero on every reload and on every step.
- R6: A change of prescale value leaves the current count untouched, and counting goes on at the new rate.
- R7: A step taken while the count is 1 or 0 is a zero event. It sets `status_rd`. In periodic mode the count reloads from the initial count and the channel stays enabled. In one-shot mode the count becomes 0 and both enable and active clear. A control or initial-count write in the same cycle takes priority over the zero event.
- R8: While enable is clear, the count holds its value and `count_rd` shows the frozen count. While enable is set, `count_rd` shows the live count.
- R9: `irq` is high exactly when the interrupt enable and `status_rd` are both set. A write with `wr_sel` = 2 clears the status when `wr_data` bit STAT_IDX (default 0) is 1. A zero event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 initial count, 2 status, 3 none |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control word read-back |
| init_rd | output | CNT_W | Initial-count register |
| count_rd | output | CNT_W | Current count |
| status_rd | output | 1 | This channel's bit of the shared status register |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs a behavioural model next to the design and compares every visible output on each clock. It also makes targeted checks at the following corner cases.

- A write with both enable and counter reset set: a design that kept the enable would start counting straight away.
- A prescale change made while the reference ticks are held off: a design that reloaded or recomputed the count would show a different value right after the write.
- A one-shot expiry: a design that forgot to drop the active flag would report a running channel that no longer counts.
- A periodic expiry: a design that failed to reload would stall at zero.
- Expiry with the interrupt enable clear, followed by setting the enable: a design that latched the interrupt separately from the status bit would miss this rise, or would keep `irq` high after the status is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTRL_W       = 32;
   localparam int CTRL_EN_BIT  = 30;
   localparam int CTRL_IE_BIT  = 29;
   localparam int CTRL_PER_BIT = 27;
   localparam int CTRL_RST_BIT = 26;
   localparam int CTRL_ACT_BIT = 25;
   localparam int PS_FIELD_W   = 8;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_INIT = 2'd1;
   localparam logic [1:0] SEL_STAT = 2'd2;

   typedef struct packed {
      logic en;
      logic ie;
      logic per;
      logic act;
   } ctrl_flags_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
   import tmr_pkg::*;
#(
   parameter int PS_W   = 8,
   parameter int PS_RST = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              zero_evt,
   output ctrl_flags_t       flags,
   output logic [PS_W-1:0]   ps,
   output logic              rst_req,
   output logic [CTRL_W-1:0] ctrl_word
);
   localparam logic [PS_W-1:0] PS_INIT = PS_W'(PS_RST);

   if (PS_W < 1 || PS_W > PS_FIELD_W) begin : g_bad_ps_w
      $error("tmr_ctrl_reg: PS_W must lie in 1..8");
   end
   if (PS_RST < 0 || PS_RST >= (1 << PS_W)) begin : g_bad_ps_rst
      $error("tmr_ctrl_reg: PS_RST does not fit PS_W bits");
   end

   logic wr_en_bit;

   assign rst_req   = ctrl_wr & wr_data[CTRL_RST_BIT];
   assign wr_en_bit = wr_data[CTRL_EN_BIT] & ~wr_data[CTRL_RST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         ps    <= PS_INIT;
      end else if (ctrl_wr) begin
         flags.en  <= wr_en_bit;
         flags.act <= wr_en_bit;
         flags.ie  <= wr_data[CTRL_IE_BIT];
         flags.per <= wr_data[CTRL_PER_BIT];
         ps        <= wr_data[PS_W-1:0];
      end else if (zero_evt && !flags.per) begin
         flags.en  <= 1'b0;
         flags.act <= 1'b0;
      end
   end

   always_comb begin
      ctrl_word               = '0;
      ctrl_word[CTRL_EN_BIT]  = flags.en;
      ctrl_word[CTRL_IE_BIT]  = flags.ie;
      ctrl_word[CTRL_PER_BIT] = flags.per;
      ctrl_word[CTRL_ACT_BIT] = flags.act;
      ctrl_word[PS_W-1:0]     = ps;
   end

   // R3: counter reset in the same write as enable leaves the channel off
   p_rst_blocks_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[CTRL_RST_BIT]) |=> !flags.en);

   // R7: one-shot expiry with no competing write stops the channel
   p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && !flags.per && !ctrl_wr) |=> (!flags.en && !flags.act));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            ref_tick,
   input  logic            restart,
   input  logic [PS_W-1:0] ps,
   output logic            step
);
   logic [PS_W-1:0] phase;
   logic            wrap;

   // >= rather than == so that lowering the prescale mid-phase cannot skip a wrap
   assign wrap = (phase >= ps);
   assign step = run & ref_tick & wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart) begin
         phase <= '0;
      end else if (run && ref_tick) begin
         phase <= wrap ? '0 : phase + 1'b1;
      end
   end

   // R5: a reload restarts the prescaler phase
   p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             periodic,
   input  logic             en,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] init_val,
   input  logic             stat_clr,
   output logic [CNT_W-1:0] count,
   output logic             status,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign zero_evt = step & (count <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (reload) begin
         count <= reload_val;
      end else if (zero_evt) begin
         count <= periodic ? init_val : '0;
      end else if (step) begin
         count <= count - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (zero_evt) begin
         status <= 1'b1;
      end else if (stat_clr) begin
         status <= 1'b0;
      end
   end

   // R5: an ordinary step lowers the count by exactly one
   p_step_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !reload && count > ONE) |=> (count == $past(count) - ONE));

   // R8: with enable clear and no reload the count is frozen
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reload) |=> $stable(count));

   // R7: every zero event leaves the status bit set
   p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> status);
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int PS_W     = 8,
   parameter int PS_RST   = 5,
   parameter int STAT_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] ctrl_rd,
   output logic [CNT_W-1:0]  init_rd,
   output logic [CNT_W-1:0]  count_rd,
   output logic              status_rd,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > CTRL_W) begin : g_bad_cnt_w
      $error("ptimer_channel: CNT_W must lie in 2..32");
   end
   if (STAT_IDX < 0 || STAT_IDX >= CTRL_W) begin : g_bad_stat_idx
      $error("ptimer_channel: STAT_IDX outside the status word");
   end

   ctrl_flags_t      flags;
   logic [PS_W-1:0]  ps;
   logic             rst_req;
   logic             ctrl_wr;
   logic             init_wr;
   logic             stat_clr;
   logic             step;
   logic             zero_evt;
   logic             reload;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] init_q;

   assign ctrl_wr  = wr_en & (wr_sel == SEL_CTRL);
   assign init_wr  = wr_en & (wr_sel == SEL_INIT);
   assign stat_clr = wr_en & (wr_sel == SEL_STAT) & wr_data[STAT_IDX];
   assign reload   = init_wr | rst_req;

   if (CNT_W == CTRL_W) begin : g_full_width
      assign reload_val = init_wr ? wr_data : init_q;
   end else begin : g_narrow
      assign reload_val = init_wr ? wr_data[CNT_W-1:0] : init_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= '0;
      end else if (init_wr) begin
         init_q <= reload_val;
      end
   end

   tmr_ctrl_reg #(.PS_W(PS_W), .PS_RST(PS_RST)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
      .zero_evt(zero_evt), .flags(flags), .ps(ps), .rst_req(rst_req),
      .ctrl_word(ctrl_rd)
   );

   tmr_prescaler #(.PS_W(PS_W)) i_pre (
      .clk(clk), .rst_n(rst_n), .run(flags.en), .ref_tick(ref_tick),
      .restart(reload), .ps(ps), .step(step)
   );

   tmr_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .periodic(flags.per),
      .en(flags.en), .reload(reload), .reload_val(reload_val),
      .init_val(init_q), .stat_clr(stat_clr), .count(count_rd),
      .status(status_rd), .zero_evt(zero_evt)
   );

   assign init_rd = init_q;
   assign irq     = flags.ie & status_rd;

   // R9: the interrupt never stands without a pending status bit
   p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status_rd);

   // R9: a pending status raises the interrupt once enabled
   p_irq_when_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && ctrl_rd[CTRL_IE_BIT]) |-> irq);

   // R4: an initial-count write shows in the count one cycle later
   p_init_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> (count_rd == init_rd));
endmodule

// File: tb/test_ptimer_channel.sv
`timescale 1ns/1ps
module test_ptimer_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_rd;
   logic [31:0] init_rd;
   logic [31:0] count_rd;
   logic        status_rd;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int tick_mode = 0;
   int cyc = 0;

   // reference model state
   bit          m_en, m_ie, m_per, m_act, m_stat;
   int unsigned m_ps, m_pre, m_init, m_cnt;

   always #10 clk = ~clk;

   ptimer_channel i_ptimer_channel (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
      .init_rd(init_rd), .count_rd(count_rd), .status_rd(status_rd),
      .irq(irq)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_ctrl();
      return (32'(m_en) << 30) | (32'(m_ie) << 29) | (32'(m_per) << 27) |
             (32'(m_act) << 25) | m_ps;
   endfunction

   // behavioural reference, stepped on each rising edge
   always @(posedge clk) begin
      bit wc, wi, ws, stp, zro, rl, ne;
      if (!rst_n) begin
         m_en = 0; m_ie = 0; m_per = 0; m_act = 0; m_stat = 0;
         m_ps = 5; m_pre = 0; m_init = 0; m_cnt = 0;
      end else begin
         wc  = wr_en && wr_sel == 2'd0;
         wi  = wr_en && wr_sel == 2'd1;
         ws  = wr_en && wr_sel == 2'd2;
         stp = m_en && ref_tick && (m_pre >= m_ps);
         zro = stp && (m_cnt <= 1);
         rl  = (wc && wr_data[26]) || wi;
         if (rl) m_pre = 0;
         else if (m_en && ref_tick) m_pre = (m_pre >= m_ps) ? 0 : m_pre + 1;
         if (wi) m_cnt = wr_data;
         else if (wc && wr_data[26]) m_cnt = m_init;
         else if (zro) m_cnt = m_per ? m_init : 0;
         else if (stp) m_cnt = m_cnt - 1;
         if (zro) m_stat = 1;
         else if (ws && wr_data[0]) m_stat = 0;
         if (wc) begin
            ne = wr_data[30] && !wr_data[26];
            m_en = ne; m_act = ne;
            m_ie = wr_data[29]; m_per = wr_data[27]; m_ps = wr_data[7:0];
         end else if (zro && !m_per) begin
            m_en = 0; m_act = 0;
         end
         if (wi) m_init = wr_data;
      end
   end

   // every-cycle comparison and tick generation, away from the rising edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         chk("R2", "ctrl_rd", ctrl_rd, m_ctrl());
         chk("R4", "init_rd", init_rd, m_init);
         chk("R5", "count_rd", count_rd, m_cnt);
         chk("R7", "status_rd", 32'(status_rd), 32'(m_stat));
         chk("R9", "irq", 32'(irq), 32'(m_stat && m_ie));
      end
      case (tick_mode)
         0: ref_tick = 1'b1;
         1: ref_tick = (cyc % 2) == 0;
         default: ref_tick = 1'b0;
      endcase
   end

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [31:0] c0;
      tick_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset ctrl", ctrl_rd, 32'h0000_0005);
      chk("R1", "reset count", count_rd, 32'h0);
      chk("R1", "reset status/irq", {30'd0, status_rd, irq}, 32'h0);

      wr(2'd1, 32'd10);
      chk("R4", "init load", count_rd, 32'd10);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R4", "sel 3 writes nothing", init_rd, 32'd10);

      wr(2'd0, 32'hFFFF_FFFF);
      chk("R3", "reset+enable drops enable", ctrl_rd, 32'h2800_00FF);
      chk("R2", "reserved dropped", ctrl_rd & 32'h81FF_FF00, 32'h0);

      // one-shot, prescale 0, interrupt enabled
      wr(2'd0, 32'h6000_0000);
      chk("R8", "enable sets active", ctrl_rd, 32'h6200_0000);
      idle(14);
      chk("R7", "one-shot stops", ctrl_rd, 32'h2000_0000);
      chk("R7", "one-shot count", count_rd, 32'h0);
      chk("R9", "irq raised", 32'(irq), 32'h1);
      wr(2'd2, 32'h1);
      chk("R9", "status cleared", {30'd0, status_rd, irq}, 32'h0);

      // periodic, prescale 2, sparse ticks
      wr(2'd1, 32'd4);
      tick_mode = 1;
      wr(2'd0, 32'h6800_0002);
      idle(60);
      chk("R7", "periodic keeps running", ctrl_rd, 32'h6A00_0002);
      chk("R7", "periodic fired", 32'(status_rd), 32'h1);

      // prescale change with ticks held off
      tick_mode = 2;
      idle(2);
      c0 = count_rd;
      wr(2'd0, 32'h6800_0007);
      chk("R6", "count kept on prescale change", count_rd, c0);
      tick_mode = 1;
      idle(40);

      // disable freezes
      wr(2'd0, 32'h0800_0007);
      c0 = count_rd;
      idle(12);
      chk("R8", "frozen count", count_rd, c0);
      chk("R8", "active cleared", ctrl_rd, 32'h0800_0007);

      // counter reset alone
      wr(2'd0, 32'h0400_0000);
      chk("R3", "counter reset reloads", count_rd, 32'd4);
      chk("R3", "reset bit reads 0", ctrl_rd, 32'h0);
      wr(2'd0, 32'h0200_0003);
      chk("R2", "active write ignored", ctrl_rd, 32'h0000_0003);

      // expiry with interrupt disabled, then enable it
      wr(2'd2, 32'h1);
      tick_mode = 0;
      wr(2'd0, 32'h4000_0000);
      idle(8);
      chk("R9", "status without ie", {30'd0, status_rd, irq}, 32'h2);
      wr(2'd0, 32'h2000_0000);
      chk("R9", "irq follows ie", 32'(irq), 32'h1);
      wr(2'd2, 32'h0);
      chk("R9", "write 0 keeps status", 32'(status_rd), 32'h1);
      wr(2'd2, 32'h1);
      chk("R9", "irq drops", 32'(irq), 32'h0);
      idle(3);
      finish_run();
   end
endmodule